// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Request Controller

This block sequences direct transfers between I/O devices and memory for four channels. It never stores the data. For each transfer it drives a 16-bit memory address, the strobe pair that suits the channel's direction, and the serviced channel's acknowledge line. The data moves on the system bus from source to sink in the same cycle. Software sets up each channel through a small register port. That setup covers a start address, a transfer count, a mode, a mask bit and an optional software request bit. A request then comes either from the channel's request pin or from its software request bit.

When an unmasked channel asks for service, the block raises its bus hold request and waits for the grant. It then runs one transfer for the winning channel, arbitrates again, and repeats. When no unmasked request is left, it releases the bus. A channel finishes when its count steps below zero or when an end-of-process pulse arrives from outside. On finishing, the channel either re-arms from its base registers or masks itself. No data stream passes through the block, so it has no valid/ready interface. The only flow control is the hold/grant pair, and the block waits for as long as the grant stays low. The bus outputs carry an enable in place of tri-state pads.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, all four mask bits are 1, the software request, command and status registers are 0, and hrq, dack, bus_en, the four strobes and eop_out are all low.
- R2: A channel requests service when (dreq OR its software request bit) is 1 and its mask bit is 0. With such a request, hrq rises, and the transfer starts only once hlda is high. A masked request has no effect.
- R3: When several channels request at once, the lowest-numbered channel wins. The chosen channel stays on dack for the whole transfer, and at most one dack bit is high.
- R4: Mode bits [1:0] select the transfer. 2'b10 (read) asserts memr and iow together. 2'b01 (write) asserts ior and memw together. 2'b00 or 2'b11 (verify) asserts no strobe.
- R5: After every transfer, the channel's current address steps by one: down if mode bit 3 is 1, up otherwise. The current count decreases by one. The address is on `addr` while the channel's dack is high.
- R6: A transfer holds dack high for 3 clock cycles with normal timing. It holds dack high for 2 cycles when command bit 0 (compressed timing) is 1. Strobes are active in the last two cycles.
- R7: The transfer made while the current count is 0 is the channel's last. eop_out pulses for one cycle during it, so a programmed count N gives N+1 transfers.
- R8: When a channel finishes and mode bit 2 (auto-reload) is 1, its current address and count are reloaded from the base values and its mask bit is unchanged. Otherwise its mask bit is set to 1.
- R9: eop_in high during any cycle of a transfer makes that transfer the channel's last, handled as in R8. eop_out stays low for it.
- R10: Status (register 15) holds a finished flag per channel in bits 3:0 and the raw requests (dreq OR software request) in bits 7:4. A status read clears bits 3:0.
- R11: A channel's software request bit clears when the channel finishes.
- R12: When command bit 1 is 1, no new hold request is raised while requests are pending.
- R13: Register map: 0-3 channel address (write sets base and current, read gives current); 4-7 channel count (same); 8-11 channel mode (6 bits); 12 mask; 13 software request; 14 command (8 bits); 15 status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe (clears status flags) |
| cpu_addr | input | 4 | Register number |
| cpu_wdata | input | 16 | Register write data |
| cpu_rdata | output | 16 | Register read data (combinational) |
| dreq | input | 4 | Hardware request per channel |
| dack | output | 4 | Acknowledge of the channel in transfer |
| hrq | output | 1 | Bus hold request |
| hlda | input | 1 | Bus hold grant |
| bus_en | output | 1 | Bus outputs driven |
| addr | output | 16 | Transfer address |
| memr | output | 1 | Memory read strobe |
| memw | output | 1 | Memory write strobe |
| ior | output | 1 | I/O read strobe |
| iow | output | 1 | I/O write strobe |
| eop_in | input | 1 | End-of-process pulse from outside |
| eop_out | output | 1 | End-of-process pulse on count underflow |

## Verification
A wrong current address shows on `addr` at the first dack cycle of the channel's next transfer. A wrong count shows at the channel's final transfer as an eop_out pulse that comes early or late, or that is missing. A mask or software request bit left in the wrong state shows within one arbitration cycle as an extra transfer or a missing one, and its value can also be read back directly. A lost finished flag or a missed clear shows at the next status read. Mis-held channel selection or timing shows within the transfer itself, as a changing dack or as the wrong number of acknowledge cycles.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  typedef enum logic [2:0] {SQ_IDLE, SQ_ARB, SQ_ADR, SQ_STB, SQ_FIN} seq_t;

  localparam int MODE_W = 6;
  localparam int CMD_W  = 8;

  // transfer kinds, mode[1:0]
  localparam logic [1:0] XF_WRITE = 2'b01;
  localparam logic [1:0] XF_READ  = 2'b10;

  // mode and command bit positions
  localparam int MB_AUTO = 2;
  localparam int MB_DEC  = 3;
  localparam int CB_FAST = 0;
  localparam int CB_OFF  = 1;

  // register groups, cpu_addr[3:2]
  localparam logic [1:0] RG_ADDR = 2'd0;
  localparam logic [1:0] RG_CNT  = 2'd1;
  localparam logic [1:0] RG_MODE = 2'd2;
  localparam logic [1:0] RG_CTL  = 2'd3;
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan import dma4_pkg::*; #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              wr_mode,
  input  logic [DW-1:0]     wdata,
  input  logic              step,
  input  logic              ending,
  output logic [MODE_W-1:0] mode,
  output logic [AW-1:0]     cur_addr,
  output logic [CW-1:0]     cur_cnt,
  output logic              last
);
  logic [AW-1:0] base_addr;
  logic [CW-1:0] base_cnt;

  assign last = (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode      <= '0;
    end else begin
      if (wr_addr) begin
        base_addr <= wdata[AW-1:0];
        cur_addr  <= wdata[AW-1:0];
      end
      if (wr_cnt) begin
        base_cnt <= wdata[CW-1:0];
        cur_cnt  <= wdata[CW-1:0];
      end
      if (wr_mode) mode <= wdata[MODE_W-1:0];
      if (step) begin
        if (ending && mode[MB_AUTO]) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
        end else begin
          cur_addr <= mode[MB_DEC] ? cur_addr - 1'b1 : cur_addr + 1'b1;
          cur_cnt  <= cur_cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic [IW-1:0]  idx,
  output logic           any
);
  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dma4_seq.sv
module dma4_seq import dma4_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic hlda,
  input  logic fast,
  input  logic eop_in,
  input  logic last,
  output logic hrq,
  output logic load,
  output logic active,
  output logic strobe,
  output logic finish,
  output logic terminate,
  output logic eop_drv
);
  seq_t st, nxt;
  logic eop_hit;

  always_comb begin
    nxt  = st;
    load = 1'b0;
    case (st)
      SQ_IDLE: if (go) nxt = SQ_ARB;
      SQ_ARB: begin
        if (!go) nxt = SQ_IDLE;
        else if (hlda) begin
          load = 1'b1;
          nxt  = fast ? SQ_STB : SQ_ADR;
        end
      end
      SQ_ADR:  nxt = SQ_STB;
      SQ_STB:  nxt = SQ_FIN;
      SQ_FIN:  nxt = SQ_ARB;
      default: nxt = SQ_IDLE;
    endcase
  end

  assign hrq       = (st != SQ_IDLE);
  assign active    = (st == SQ_ADR) || (st == SQ_STB) || (st == SQ_FIN);
  assign strobe    = (st == SQ_STB) || (st == SQ_FIN);
  assign finish    = (st == SQ_FIN);
  assign terminate = finish && (last || eop_hit || eop_in);
  assign eop_drv   = finish && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      eop_hit <= 1'b0;
    end else begin
      st <= nxt;
      if (load) eop_hit <= 1'b0;
      else if (active && eop_in) eop_hit <= 1'b1;
    end
  end
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl import dma4_pkg::*; #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int DW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_we,
  input  logic           cpu_re,
  input  logic [3:0]     cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  output logic           hrq,
  input  logic           hlda,
  output logic           bus_en,
  output logic [AW-1:0]  addr,
  output logic           memr,
  output logic           memw,
  output logic           ior,
  output logic           iow,
  input  logic           eop_in,
  output logic           eop_out
);
  logic [1:0]       grp;
  logic [IW-1:0]    sel;
  logic [NCH-1:0]   mask_q, swreq_q, tc_q, raw_req, eff_req;
  logic [CMD_W-1:0] cmd_q;
  logic [IW-1:0]    win_idx, ch_q;
  logic             any_req, go, load, active, strobe, finish, terminate;
  logic [MODE_W-1:0] mode_a  [NCH];
  logic [AW-1:0]     caddr_a [NCH];
  logic [CW-1:0]     ccnt_a  [NCH];
  logic [NCH-1:0]    last_v;
  logic [1:0]        xt;

  assign grp     = cpu_addr[3:2];
  assign sel     = cpu_addr[IW-1:0];
  assign raw_req = dreq | swreq_q;
  assign eff_req = raw_req & ~mask_q;
  assign go      = any_req && !cmd_q[CB_OFF];

  dma4_arb #(.NCH(NCH)) u_arb (.req(eff_req), .idx(win_idx), .any(any_req));

  dma4_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .hlda(hlda), .fast(cmd_q[CB_FAST]),
    .eop_in(eop_in), .last(last_v[ch_q]), .hrq(hrq), .load(load),
    .active(active), .strobe(strobe), .finish(finish),
    .terminate(terminate), .eop_drv(eop_out)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma4_chan #(.AW(AW), .CW(CW), .DW(DW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_addr(cpu_we && grp == RG_ADDR && sel == IW'(c)),
      .wr_cnt (cpu_we && grp == RG_CNT  && sel == IW'(c)),
      .wr_mode(cpu_we && grp == RG_MODE && sel == IW'(c)),
      .wdata(cpu_wdata),
      .step(finish && ch_q == IW'(c)),
      .ending(terminate),
      .mode(mode_a[c]), .cur_addr(caddr_a[c]), .cur_cnt(ccnt_a[c]),
      .last(last_v[c])
    );
  end

  // transfer outputs
  assign xt     = mode_a[ch_q][1:0];
  assign bus_en = active;
  assign addr   = active ? caddr_a[ch_q] : '0;
  assign memr   = strobe && xt == XF_READ;
  assign iow    = strobe && xt == XF_READ;
  assign ior    = strobe && xt == XF_WRITE;
  assign memw   = strobe && xt == XF_WRITE;

  always_comb begin
    dack = '0;
    if (active) dack[ch_q] = 1'b1;
  end

  // control registers and channel latch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      swreq_q <= '0;
      cmd_q   <= '0;
      tc_q    <= '0;
      ch_q    <= '0;
    end else begin
      if (load) ch_q <= win_idx;
      if (cpu_we && grp == RG_CTL) begin
        case (cpu_addr[1:0])
          2'd0:    mask_q  <= cpu_wdata[NCH-1:0];
          2'd1:    swreq_q <= cpu_wdata[NCH-1:0];
          2'd2:    cmd_q   <= cpu_wdata[CMD_W-1:0];
          default: ;
        endcase
      end
      if (cpu_re && grp == RG_CTL && cpu_addr[1:0] == 2'd3) tc_q <= '0;
      if (terminate) begin
        tc_q[ch_q]    <= 1'b1;
        swreq_q[ch_q] <= 1'b0;
        if (!mode_a[ch_q][MB_AUTO]) mask_q[ch_q] <= 1'b1;
      end
    end
  end

  // register read
  always_comb begin
    cpu_rdata = '0;
    case (grp)
      RG_ADDR: cpu_rdata[AW-1:0]     = caddr_a[sel];
      RG_CNT:  cpu_rdata[CW-1:0]     = ccnt_a[sel];
      RG_MODE: cpu_rdata[MODE_W-1:0] = mode_a[sel];
      default: begin
        case (cpu_addr[1:0])
          2'd0:    cpu_rdata[NCH-1:0]   = mask_q;
          2'd1:    cpu_rdata[NCH-1:0]   = swreq_q;
          2'd2:    cpu_rdata[CMD_W-1:0] = cmd_q;
          default: cpu_rdata[2*NCH-1:0] = {raw_req, tc_q};
        endcase
      end
    endcase
  end
endmodule

// File: rtl/dma4_chk.sv
module dma4_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] dack,
  input logic           hrq,
  input logic           memr,
  input logic           memw,
  input logic           ior,
  input logic           iow,
  input logic           eop_out
);
  // R3
  dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  // R2
  dack_under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> hrq);

  // R3
  dack_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dack) && $past(|dack)) |-> (dack == $past(dack)));

  // R4
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(memr && memw) && !(ior && iow));

  // R6
  strobe_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memr || memw || ior || iow) |-> (|dack));

  // R7
  eop_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_out |-> (|dack));

  // R7
  eop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_out |=> !eop_out);
endmodule

bind dma4_ctrl dma4_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dack(dack), .hrq(hrq), .memr(memr),
  .memw(memw), .ior(ior), .iow(iow), .eop_out(eop_out)
);

// File: tb/tb_dma4_ctrl.sv
module tb_dma4_ctrl;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0, cpu_re = 1'b0;
  logic [3:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack;
  logic        hrq, hlda = 1'b0, bus_en;
  logic [15:0] addr;
  logic        memr, memw, ior, iow;
  logic        eop_in = 1'b0, eop_out;

  dma4_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dreq(dreq), .dack(dack), .hrq(hrq), .hlda(hlda), .bus_en(bus_en),
    .addr(addr), .memr(memr), .memw(memw), .ior(ior), .iow(iow),
    .eop_in(eop_in), .eop_out(eop_out)
  );

  always #(CLK_NS / 2) clk = ~clk;

  // bus owner grants half a cycle after each request change
  always @(negedge clk) hlda <= hrq;

  typedef struct {
    int          ch;
    logic [15:0] a;
    logic [3:0]  s;   // {memr, memw, ior, iow}
    int          cyc;
    bit          eop;
  } xfer_t;

  localparam logic [3:0] S_RD = 4'b1001;
  localparam logic [3:0] S_WR = 4'b0110;
  localparam logic [3:0] S_VF = 4'b0000;

  xfer_t expq[$];
  xfer_t cur;
  bit    inx = 0;
  bit    done = 0;
  int    errors = 0;
  int    checks = 0;

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(int ch, logic [15:0] a, logic [3:0] s, int cyc, bit eop);
    xfer_t t;
    t.ch = ch; t.a = a; t.s = s; t.cyc = cyc; t.eop = eop;
    expq.push_back(t);
  endtask

  function automatic int dack_idx(logic [3:0] d);
    int r = -1;
    for (int i = 0; i < 4; i++) if (d[i]) r = i;
    return r;
  endfunction

  // monitor: gathers one transfer per dack window and compares it
  always @(negedge clk) begin
    if (rst_n) begin
      if (|dack) begin
        if (!inx) begin
          inx = 1;
          cur.ch = dack_idx(dack);
          cur.a = addr;
          cur.s = {memr, memw, ior, iow};
          cur.cyc = 1;
          cur.eop = eop_out;
        end else begin
          cur.s = cur.s | {memr, memw, ior, iow};
          cur.cyc++;
          cur.eop = cur.eop | eop_out;
        end
      end else if (inx) begin
        inx = 0;
        if (expq.size() == 0) begin
          check_eq("R2", "unexpected transfer on channel", cur.ch, 32'hFFFF);
        end else begin
          xfer_t e;
          e = expq.pop_front();
          check_eq("R3", "channel", cur.ch, e.ch);
          check_eq("R5", "address", cur.a, e.a);
          check_eq("R4", "strobes", cur.s, e.s);
          check_eq("R6", "dack cycles", cur.cyc, e.cyc);
          check_eq("R7", "eop_out", cur.eop, e.eop);
        end
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_re = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_re = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((expq.size() != 0 || inx || hrq) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check_eq("R2", "expected transfers left", expq.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_eq("R1", "hrq", hrq, 0);
    check_eq("R1", "dack", dack, 0);
    check_eq("R1", "bus_en", bus_en, 0);
    check_eq("R1", "strobes", {memr, memw, ior, iow, eop_out}, 0);
    rd(4'd12, v); check_eq("R1", "mask", v, 16'h000F);
    rd(4'd15, v); check_eq("R1", "status", v, 16'h0000);

    // R13 R4 R5 R7 R8: channel 1 read, up, count 2 -> three transfers
    wr(4'd1, 16'h1000); wr(4'd5, 16'd2); wr(4'd9, 16'h0002);
    dreq[1] = 1'b1;
    repeat (6) @(negedge clk);
    check_eq("R2", "hrq while masked", hrq, 0);
    push(1, 16'h1000, S_RD, 3, 0);
    push(1, 16'h1001, S_RD, 3, 0);
    push(1, 16'h1002, S_RD, 3, 1);
    wr(4'd12, 16'h000D);
    wait_idle();
    rd(4'd12, v); check_eq("R8", "mask after finish", v, 16'h000F);
    rd(4'd15, v); check_eq("R10", "status after finish", v, 16'h0022);
    rd(4'd15, v); check_eq("R10", "status after clear", v, 16'h0020);
    rd(4'd1, v);  check_eq("R5", "current address", v, 16'h1003);
    rd(4'd5, v);  check_eq("R5", "current count", v, 16'hFFFF);
    dreq[1] = 1'b0;

    // R3 priority: ch0 (pin, write, down) against ch2 (software, verify)
    wr(4'd0, 16'h0020); wr(4'd4, 16'd1); wr(4'd8, 16'h0009);
    wr(4'd2, 16'h0300); wr(4'd6, 16'd0); wr(4'd10, 16'h0000);
    dreq[0] = 1'b1;
    wr(4'd13, 16'h0004);
    push(0, 16'h0020, S_WR, 3, 0);
    push(0, 16'h001F, S_WR, 3, 1);
    push(2, 16'h0300, S_VF, 3, 1);
    wr(4'd12, 16'h000A);
    wait_idle();
    dreq[0] = 1'b0;
    rd(4'd13, v); check_eq("R11", "software requests", v, 16'h0000);
    rd(4'd12, v); check_eq("R8", "mask after both", v, 16'h000F);
    rd(4'd15, v); check_eq("R10", "status two channels", v, 16'h0005);

    // R6 compressed timing with R8 auto-reload on ch3
    wr(4'd14, 16'h0001);
    wr(4'd3, 16'h0050); wr(4'd7, 16'd1); wr(4'd11, 16'h0006);
    push(3, 16'h0050, S_RD, 2, 0);
    push(3, 16'h0051, S_RD, 2, 1);
    wr(4'd13, 16'h0008);
    wr(4'd12, 16'h0007);
    wait_idle();
    rd(4'd12, v); check_eq("R8", "mask kept on reload", v, 16'h0007);
    rd(4'd3, v);  check_eq("R8", "reloaded address", v, 16'h0050);
    rd(4'd7, v);  check_eq("R8", "reloaded count", v, 16'h0001);
    rd(4'd13, v); check_eq("R11", "software request cleared", v, 16'h0000);
    push(3, 16'h0050, S_RD, 2, 0);
    push(3, 16'h0051, S_RD, 2, 1);
    wr(4'd13, 16'h0008);
    wait_idle();
    wr(4'd14, 16'h0000);

    // R12 controller disabled
    wr(4'd14, 16'h0002);
    wr(4'd13, 16'h0008);
    repeat (12) @(negedge clk);
    check_eq("R12", "hrq while disabled", hrq, 0);
    check_eq("R12", "dack while disabled", dack, 0);
    rd(4'd15, v); check_eq("R10", "pending request in status", v, 16'h0088);
    push(3, 16'h0050, S_RD, 3, 0);
    push(3, 16'h0051, S_RD, 3, 1);
    wr(4'd14, 16'h0000);
    wait_idle();

    // R9 external end-of-process on ch1 during its second transfer
    wr(4'd1, 16'h0400); wr(4'd5, 16'd10);
    push(1, 16'h0400, S_RD, 3, 0);
    push(1, 16'h0401, S_RD, 3, 0);
    dreq[1] = 1'b1;
    wr(4'd12, 16'h0005);
    begin
      int n = 0;
      while (!(dack[1] && addr == 16'h0401) && n < 500) begin
        @(negedge clk);
        n++;
      end
    end
    eop_in = 1'b1;
    @(negedge clk);
    eop_in = 1'b0;
    wait_idle();
    dreq[1] = 1'b0;
    rd(4'd12, v); check_eq("R9", "mask after external end", v, 16'h0007);
    rd(4'd1, v);  check_eq("R9", "address after external end", v, 16'h0402);
    rd(4'd5, v);  check_eq("R9", "count after external end", v, 16'd8);
    rd(4'd15, v); check_eq("R10", "status after external end", v, 16'h000A);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule